// File: doc/BRIEF.md
# Audio Sample Write Router

This block takes 32-bit sample words from a bus-side write port and decides which of two per-channel sample queues each word feeds. Every push carries a 24-bit sample and an 8-bit control field. The queues themselves are outside the block. Each channel has a full flag as an input, and the write port stalls when a channel it needs is full.

How a write is routed depends on five settings:
- the container size (8, 16, 24 or 32 bits);
- a transfer mode, used only with the 24-bit container;
- a valid-bit count;
- an alignment bit;
- a mono/dual flag.

The transfer mode selects one of four ways to pick the channel:
- an explicit channel index carried in the write;
- a pointer that alternates between the channels;
- the same alternating pointer, with a control byte forwarded alongside the sample;
- a packed format that carries four 24-bit samples in three words.

In every case, the valid bits are taken out of the container and placed MSB-aligned in the 24-bit output sample. All other output bits are cleared.

Top module: `audio_wr_router`

## Requirements
- R1: The transfer mode (`cfg_mode`) is honoured only when `cfg_size` is 2 (24-bit container). With any other size, writes alternate between the channels exactly as in mode 1, and the control field is 0.
- R2: In mode 0 with `cfg_dual`=1, bits [25:24] of the write choose the channel: 1 selects channel 1 and 2 selects channel 2. The sample comes from bits [23:0].
- R3: In mode 1, and for containers other than 24 bits, accepted writes alternate between channel 1 and channel 2. The first write after reset goes to channel 1. A stalled write does not move the pointer.
- R4: Mode 3 alternates like mode 1 and sends bits [31:24] of the write as the control field. In every other mode the control field is 0.
- R5: Mode 2 packs four samples into three writes, least significant byte first. Write 0 sends bytes 0-2 to channel 1. Write 1 sends bytes 3-5 to channel 2. Write 2 sends bytes 6-8 to channel 1 and bytes 9-11 to channel 2 in the same cycle. Leftover bytes are held between writes.
- R6: In dual mode 0, a channel index of 0 or 3 is accepted but pushes nothing. It sets `idx_err` from the next cycle onward, and only reset clears the flag.
- R7: Container widths are 8, 16, 24 and 32 bits for sizes 0 to 3. With `cfg_msb_just`=0 the valid bits are taken from the low end of the container; with 1, from the high end. They are placed MSB-aligned in the 24-bit sample, with the other bits cleared. A field wider than 24 bits keeps its top 24 bits.
- R8: A valid-bit count below 2 or above the container width is treated as the full container width.
- R9: With `cfg_dual`=0, every sample is pushed to both channels in the same cycle with the same value, and the channel index is ignored.
- R10: In mono mode, the third write of a packed group pushes its first sample at once. The second sample is pushed to both channels in the next cycle, and `wr_ready` is 0 during that cycle.
- R11: `wr_ready` is 0 while any channel that the current write would push to is full. No push is ever made to a full channel.
- R12: Pushes for a write happen in the same cycle the write is accepted (`wr_valid` and `wr_ready` both 1), with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 2 | Container size code |
| cfg_mode | input | 2 | Transfer mode (used only when the size code is 2) |
| cfg_msb_just | input | 1 | Valid-bit alignment: 0 = low end, 1 = high end |
| cfg_vbits | input | 6 | Valid bits per sample |
| cfg_dual | input | 1 | 1 = independent channels, 0 = mono duplicate |
| wr_valid | input | 1 | Write request |
| wr_data | input | 32 | Write word |
| wr_ready | output | 1 | Write can be accepted this cycle |
| ch1_push | output | 1 | Push to channel 1 queue |
| ch1_sample | output | 24 | Channel 1 sample |
| ch1_ctrl | output | 8 | Channel 1 control field |
| ch1_full | input | 1 | Channel 1 queue full |
| ch2_push | output | 1 | Push to channel 2 queue |
| ch2_sample | output | 24 | Channel 2 sample |
| ch2_ctrl | output | 8 | Channel 2 control field |
| ch2_full | input | 1 | Channel 2 queue full |
| idx_err | output | 1 | Sticky bad-index flag |

## Verification
Pushes, samples, control fields and `wr_ready` depend only on inputs and current state, so they are due in the same cycle as the write. The bench drives each write just after a falling edge and samples a few nanoseconds later, before the next rising edge.

Three results are due one edge later:
- the alternating pointer's next choice;
- the `idx_err` flag;
- the held second sample of a mono packed group.

For these, the bench checks in the cycle after the accepting edge, again away from the edge.

// File: rtl/awr_pkg.sv
package awr_pkg;
  localparam int DATA_W   = 32;
  localparam int SAMPLE_W = 24;
  localparam int CTRL_W   = 8;
  localparam int RES_W    = 16;

  typedef enum logic [1:0] {
    M_INDEX   = 2'd0,
    M_TOGGLE  = 2'd1,
    M_PACKED  = 2'd2,
    M_CTRLBYT = 2'd3
  } xfer_mode_e;

  // container width in bits for a size code
  function automatic logic [5:0] cont_width(input logic [1:0] size);
    return (6'(size) + 6'd1) << 3;
  endfunction

  // out-of-range counts fall back to the full container
  function automatic logic [5:0] vbits_eff(input logic [5:0] vb, input logic [5:0] cw);
    return (vb < 6'd2 || vb > cw) ? cw : vb;
  endfunction

  // extract the valid window and place it MSB-aligned in 24 bits
  function automatic logic [SAMPLE_W-1:0] align_sample(input logic [DATA_W-1:0] v,
      input logic [5:0] cw, input logic [5:0] vb, input logic msb);
    logic [DATA_W-1:0] m;
    logic [DATA_W-1:0] f;
    m = (vb == 6'd32) ? '1 : ((32'd1 << vb) - 32'd1);
    f = msb ? ((v >> (cw - vb)) & m) : (v & m);
    if (vb <= 6'd24) f = f << (6'd24 - vb);
    else             f = f >> (vb - 6'd24);
    return f[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/awr_packer.sv
module awr_packer
  import awr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                take_packed,
  input  logic                take_other,
  input  logic                mono,
  input  logic                drain,
  output logic [1:0]          phase,
  output logic [SAMPLE_W-1:0] samp_a,
  output logic [SAMPLE_W-1:0] samp_b,
  output logic                pend_vld,
  output logic [SAMPLE_W-1:0] pend_samp
);
  logic [RES_W-1:0] resid;

  always_comb begin
    samp_b = wr_data[31:8];
    case (phase)
      2'd0:    samp_a = wr_data[23:0];
      2'd1:    samp_a = {wr_data[15:0], resid[7:0]};
      default: samp_a = {wr_data[7:0], resid};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 2'd0;
      resid     <= '0;
      pend_vld  <= 1'b0;
      pend_samp <= '0;
    end else begin
      if (drain) pend_vld <= 1'b0;
      if (take_packed) begin
        phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
        resid <= (phase == 2'd0) ? {8'h00, wr_data[31:24]} : wr_data[31:16];
        if (phase == 2'd2 && mono) begin
          pend_vld  <= 1'b1;
          pend_samp <= samp_b;
        end
      end else if (take_other) begin
        phase <= 2'd0;
      end
    end
  end

  // R10
  mono_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_packed && phase == 2'd2 && mono) |=> pend_vld);
endmodule

// File: rtl/awr_steer.sv
module awr_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic take_toggle,
  input  logic take_bad,
  output logic ptr_ch2,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_ch2 <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (take_toggle) ptr_ch2 <= ~ptr_ch2;
      if (take_bad)    err     <= 1'b1;
    end
  end

  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_toggle |=> (ptr_ch2 != $past(ptr_ch2)));
  // R6
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> err);
endmodule

// File: rtl/audio_wr_router.sv
module audio_wr_router
  import awr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_size,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_msb_just,
  input  logic [5:0]          cfg_vbits,
  input  logic                cfg_dual,
  input  logic                wr_valid,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                wr_ready,
  output logic                ch1_push,
  output logic [SAMPLE_W-1:0] ch1_sample,
  output logic [CTRL_W-1:0]   ch1_ctrl,
  input  logic                ch1_full,
  output logic                ch2_push,
  output logic [SAMPLE_W-1:0] ch2_sample,
  output logic [CTRL_W-1:0]   ch2_ctrl,
  input  logic                ch2_full,
  output logic                idx_err
);
  // decoded configuration
  logic        wide24, is_index, is_packed, ctrl_on;
  logic [5:0]  cw, vb, cw_eff, vb_eff;
  // internal events, named for the checks
  logic        want1, want2, pair_push, blocked, accept, drain;
  logic        take_toggle, take_bad, take_packed, take_other;
  logic        ptr_ch2, pend_vld;
  logic [1:0]  phase;
  logic [SAMPLE_W-1:0] samp_a, samp_b, pend_samp;
  logic [SAMPLE_W-1:0] al_a, al_b, al_pend;

  assign wide24    = (cfg_size == 2'd2);
  assign is_index  = wide24 && (cfg_mode == M_INDEX);
  assign is_packed = wide24 && (cfg_mode == M_PACKED);
  assign ctrl_on   = wide24 && (cfg_mode == M_CTRLBYT);
  assign cw        = cont_width(cfg_size);
  assign vb        = vbits_eff(cfg_vbits, cw);
  assign cw_eff    = is_packed ? 6'd24 : cw;
  assign vb_eff    = vbits_eff(cfg_vbits, cw_eff);

  assign al_a    = is_packed ? align_sample({8'h00, samp_a}, cw_eff, vb_eff, cfg_msb_just)
                             : align_sample(wr_data, cw, vb, cfg_msb_just);
  assign al_b    = align_sample({8'h00, samp_b}, 6'd24, vb_eff, cfg_msb_just);
  assign al_pend = align_sample({8'h00, pend_samp}, 6'd24, vb_eff, cfg_msb_just);

  always_comb begin
    want1 = 1'b0;
    want2 = 1'b0;
    pair_push = 1'b0;
    if (!cfg_dual) begin
      want1 = 1'b1;
      want2 = 1'b1;
    end else if (is_packed) begin
      want1 = (phase != 2'd1);
      want2 = (phase != 2'd0);
      pair_push = (phase == 2'd2);
    end else if (is_index) begin
      want1 = (wr_data[25:24] == 2'd1);
      want2 = (wr_data[25:24] == 2'd2);
    end else begin
      want1 = !ptr_ch2;
      want2 = ptr_ch2;
    end
  end

  assign blocked  = (want1 && ch1_full) || (want2 && ch2_full);
  assign wr_ready = !pend_vld && !blocked;
  assign accept   = wr_valid && wr_ready;
  assign drain    = pend_vld && !ch1_full && !ch2_full;

  assign take_packed = accept && is_packed;
  assign take_other  = accept && !is_packed;
  assign take_toggle = accept && cfg_dual && !is_packed && !is_index;
  assign take_bad    = accept && cfg_dual && is_index && !want1 && !want2;

  assign ch1_push   = pend_vld ? drain : (accept && want1);
  assign ch2_push   = pend_vld ? drain : (accept && want2);
  assign ch1_sample = pend_vld ? al_pend : al_a;
  assign ch2_sample = pend_vld ? al_pend : (pair_push ? al_b : al_a);
  assign ch1_ctrl   = (ctrl_on && !pend_vld) ? wr_data[31:24] : '0;
  assign ch2_ctrl   = ch1_ctrl;

  awr_packer u_packer (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .take_packed(take_packed), .take_other(take_other),
    .mono(!cfg_dual), .drain(drain), .phase(phase),
    .samp_a(samp_a), .samp_b(samp_b),
    .pend_vld(pend_vld), .pend_samp(pend_samp)
  );

  awr_steer u_steer (
    .clk(clk), .rst_n(rst_n), .take_toggle(take_toggle),
    .take_bad(take_bad), .ptr_ch2(ptr_ch2), .err(idx_err)
  );

  // R11
  ch1_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_push |-> !ch1_full);
  // R11
  ch2_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_push |-> !ch2_full);
  // R9
  mono_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dual && ch1_push) |-> (ch2_push && ch2_sample == ch1_sample));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> idx_err);
  // R10
  pend_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |-> !wr_ready);
endmodule

// File: tb/tb_audio_wr_router.sv
module tb_audio_wr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_size = 2'd2;
  logic [1:0]  cfg_mode = 2'd1;
  logic        cfg_msb_just = 1'b0;
  logic [5:0]  cfg_vbits = 6'd24;
  logic        cfg_dual = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ch1_full = 1'b0, ch2_full = 1'b0;
  logic        wr_ready, ch1_push, ch2_push, idx_err;
  logic [23:0] ch1_sample, ch2_sample;
  logic [7:0]  ch1_ctrl, ch2_ctrl;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_wr_router dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bit-by-bit model of the valid-window extraction
  function automatic logic [23:0] ref_al(logic [31:0] v, int cw, int vbr, bit msb);
    int vb;
    logic [23:0] r;
    r = '0;
    vb = (vbr < 2 || vbr > cw) ? cw : vbr;
    for (int k = 0; k < vb; k++) begin
      int src, dst;
      src = msb ? (cw - vb + k) : k;
      dst = k + 24 - vb;
      if (dst >= 0 && dst < 24) r[dst] = v[src];
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    wr_valid = 0; ch1_full = 0; ch2_full = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  // present a write just after a falling edge; outputs settle before the rising edge
  task automatic present(logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    #2;
  endtask

  task automatic retire();
    @(posedge clk);
    #1 wr_valid = 0;
  endtask

  task automatic push_chk(string req, bit e1, bit e2, logic [23:0] s1, logic [23:0] s2, logic [7:0] c);
    chk(req, ch1_push, e1);
    chk(req, ch2_push, e2);
    if (e1) chk(req, ch1_sample, s1);
    if (e2) chk(req, ch2_sample, s2);
    if (e1) chk(req, ch1_ctrl, c);
    if (e2) chk(req, ch2_ctrl, c);
  endtask

  task automatic t_reset();
    do_reset();
    #2;
    chk("R12 reset push1", ch1_push, 0);
    chk("R12 reset push2", ch2_push, 0);
    chk("R6 reset err", idx_err, 0);
    chk("R11 reset ready", wr_ready, 1);
  endtask

  task automatic t_index();
    cfg_size = 2; cfg_mode = 0; cfg_dual = 1; cfg_vbits = 24; cfg_msb_just = 0;
    do_reset();
    present(32'h01AB_CDEF); push_chk("R2 idx1", 1, 0, 24'hABCDEF, 0, 0); retire();
    present(32'hFE12_3456); push_chk("R2 idx2", 0, 1, 0, 24'h123456, 0); retire();
    present(32'h0011_1111); chk("R6 idx0 ready", wr_ready, 1);
    push_chk("R6 idx0 dropped", 0, 0, 0, 0, 0); retire();
    #2 chk("R6 err set", idx_err, 1);
    present(32'h0111_1111); push_chk("R2 idx1 after err", 1, 0, 24'h111111, 0, 0); retire();
    #2 chk("R6 err sticky", idx_err, 1);
  endtask

  task automatic t_toggle();
    cfg_size = 2; cfg_mode = 1; cfg_dual = 1; cfg_vbits = 24;
    do_reset();
    present(32'hFF00_0001); push_chk("R3 first ch1", 1, 0, 24'h000001, 0, 0); retire();
    present(32'h0000_0002); push_chk("R3 second ch2", 0, 1, 0, 24'h000002, 0); retire();
    present(32'h0000_0003); push_chk("R3 third ch1", 1, 0, 24'h000003, 0, 0); retire();
  endtask

  task automatic t_ctrl();
    cfg_size = 2; cfg_mode = 3; cfg_dual = 1; cfg_vbits = 24;
    do_reset();
    present(32'h5A12_3456); push_chk("R4 ctrl ch1", 1, 0, 24'h123456, 0, 8'h5A); retire();
    present(32'hC3AB_CDEF); push_chk("R4 ctrl ch2", 0, 1, 0, 24'hABCDEF, 8'hC3); retire();
  endtask

  task automatic t_packed(bit mono);
    cfg_size = 2; cfg_mode = 2; cfg_dual = !mono; cfg_vbits = 24;
    do_reset();
    present(32'h0302_0100);
    push_chk(mono ? "R9 packed w0" : "R5 packed w0", 1, mono, 24'h020100, 24'h020100, 0); retire();
    present(32'h0706_0504);
    push_chk(mono ? "R9 packed w1" : "R5 packed w1", mono, 1, 24'h050403, 24'h050403, 0); retire();
    present(32'h0B0A_0908);
    if (!mono) push_chk("R5 packed w2", 1, 1, 24'h080706, 24'h0B0A09, 0);
    else       push_chk("R10 packed w2", 1, 1, 24'h080706, 24'h080706, 0);
    retire();
    if (mono) begin
      #2;
      chk("R10 stall", wr_ready, 0);
      push_chk("R10 held sample", 1, 1, 24'h0B0A09, 24'h0B0A09, 0);
      @(posedge clk); #2;
      chk("R10 ready back", wr_ready, 1);
    end
  endtask

  task automatic t_size_ignores_mode();
    cfg_size = 1; cfg_mode = 0; cfg_dual = 1; cfg_vbits = 16; cfg_msb_just = 0;
    do_reset();
    present(32'hA602_BEEF); push_chk("R1 size1 toggles ch1", 1, 0, 24'hBEEF00, 0, 0); retire();
    present(32'hA601_1234); push_chk("R1 size1 toggles ch2", 0, 1, 0, 24'h123400, 0); retire();
    #2 chk("R1 no idx err", idx_err, 0);
  endtask

  task automatic t_justify();
    logic [31:0] d;
    cfg_mode = 1; cfg_dual = 0;
    do_reset();
    cfg_size = 3; cfg_vbits = 12; cfg_msb_just = 0; d = 32'hFFFF_FABC;
    present(d); push_chk("R7 lsb 12/32", 1, 1, ref_al(d, 32, 12, 0), ref_al(d, 32, 12, 0), 0); retire();
    cfg_msb_just = 1; d = 32'hABCF_FFFF;
    present(d); push_chk("R7 msb 12/32", 1, 1, 24'hABC000, 24'hABC000, 0); retire();
    cfg_msb_just = 0; cfg_vbits = 28; d = 32'hFABC_DEF1;
    present(d); push_chk("R7 wide 28/32", 1, 1, 24'hABCDEF, 24'hABCDEF, 0); retire();
    cfg_size = 0; cfg_vbits = 5; cfg_msb_just = 1; d = 32'h1234_56F3;
    present(d); push_chk("R7 msb 5/8", 1, 1, ref_al(d, 8, 5, 1), ref_al(d, 8, 5, 1), 0); retire();
    cfg_size = 1; cfg_vbits = 0; cfg_msb_just = 0; d = 32'hFFFF_1234;
    present(d); push_chk("R8 vb0 -> 16", 1, 1, 24'h123400, 24'h123400, 0); retire();
    cfg_vbits = 40; d = 32'h0000_8001;
    present(d); push_chk("R8 vb40 -> 16", 1, 1, 24'h800100, 24'h800100, 0); retire();
  endtask

  task automatic t_mono_index();
    cfg_size = 2; cfg_mode = 0; cfg_dual = 0; cfg_vbits = 24; cfg_msb_just = 0;
    do_reset();
    present(32'h0365_4321); push_chk("R9 mono ignores idx", 1, 1, 24'h654321, 24'h654321, 0); retire();
    #2 chk("R9 mono no err", idx_err, 0);
  endtask

  task automatic t_backpressure();
    cfg_size = 2; cfg_mode = 1; cfg_dual = 1; cfg_vbits = 24;
    do_reset();
    ch1_full = 1;
    present(32'h0000_0AAA);
    chk("R11 ready low ch1 full", wr_ready, 0);
    push_chk("R11 no push", 0, 0, 0, 0, 0);
    retire();
    @(negedge clk); ch1_full = 0;
    present(32'h0000_0BBB); push_chk("R3 stall kept ptr", 1, 0, 24'h000BBB, 0, 0); retire();
    cfg_mode = 0;
    do_reset();
    ch1_full = 1;
    present(32'h0200_0CCC);
    chk("R11 other full ok", wr_ready, 1);
    push_chk("R11 ch2 while ch1 full", 0, 1, 0, 24'h000CCC, 0); retire();
    ch1_full = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_index();
    t_toggle();
    t_ctrl();
    t_packed(0);
    t_packed(1);
    t_size_ignores_mode();
    t_justify();
    t_mono_index();
    t_backpressure();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule